// File: doc/BRIEF.md
# Guarded Input Choice with Timeout

This control unit picks between two continuations once a start pulse arrives. From that start it waits for a peer to offer a word on an input channel. If an offer comes first, the unit takes the word, latches it and pulses the input-branch start. If N clock cycles pass with no offer, it pulses the timeout-branch start instead. The branch bodies sit outside the unit. Each reports completion with a one-cycle done pulse. The unit merges the two done pulses into one finish pulse, delayed by one flop.

The unit tells the channel peer it can receive for as long as it is active. Active means the start cycle plus every cycle spent in the wait flop. An offer seen in the same cycle that the timer runs out still wins. A start pulse that arrives while the unit is already waiting restarts the deadline from that cycle.

Top module: `gic_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `recv_rdy_o`, `in_go_o`, `to_go_o` and `finish_o` are 0 and `data_o` is all zeros.
- R2: `recv_rdy_o` is 1 in the start cycle and in every later cycle until a branch is chosen, and it is 0 otherwise.
- R3: In any cycle where `recv_rdy_o` is 1 and `offer_i` is 1, `in_go_o` pulses in that same cycle. This includes the start cycle itself.
- R4: The cycle after `in_go_o`, `data_o` holds the `data_i` value from the cycle of the take. At all other times `data_o` keeps its value.
- R5: If there is no offer, `to_go_o` pulses exactly N cycles after the start cycle, where the start cycle is counted as cycle 0. The unit is then inactive.
- R6: An offer in the deadline cycle starts the input branch, and no `to_go_o` pulse occurs.
- R7: Once the input branch is chosen, the timer is cancelled. There is no later `to_go_o` pulse and `recv_rdy_o` stays low until the next start.
- R8: `finish_o` is 1 exactly in the cycle after a cycle in which `in_done_i` or `to_done_i` (or both) is 1.
- R9: An offer while the unit is inactive has no effect: `in_go_o` stays 0 and `data_o` is unchanged.
- R10: A start pulse during a wait restarts the deadline, so `to_go_o` then comes N cycles after the newest start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for the choice |
| offer_i | input | 1 | Channel peer offers a word this cycle |
| data_i | input | DW | Offered word |
| in_done_i | input | 1 | Input-branch body finished |
| to_done_i | input | 1 | Timeout-branch body finished |
| recv_rdy_o | output | 1 | Unit is ready to receive (active) |
| in_go_o | output | 1 | Input branch start and take acknowledge |
| to_go_o | output | 1 | Timeout branch start |
| data_o | output | DW | Last word taken |
| finish_o | output | 1 | Merged finish pulse |

## Verification
The hardest case to reach is the tie: an offer that lands in the exact cycle the deadline is reached. The stimulus starts the unit and holds the offer low for N-1 cycles. It then raises the offer in cycle N, which is where the timer would otherwise fire. It also reaches, on purpose, a restart in the middle of a wait and both done pulses in the same cycle. A behavioural model that counts elapsed cycles is compared against every output on every clock.

// File: rtl/gic_pkg.sv
package gic_pkg;
  // bits needed to hold a count of 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gic_timer.sv
module gic_timer #(
  parameter int N = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic armed_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = gic_pkg::cnt_bits(N);
  localparam logic [CW-1:0] LIMIT = CW'(N);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(1);
    else              cnt_q <= cnt_q + CW'(1);
  end

  assign expired_o = armed_i & ~start_i & (cnt_q == LIMIT);
endmodule

// File: rtl/gic_guard.sv
module gic_guard (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic offer_i,
  input  logic expired_i,
  output logic wait_q_o,
  output logic wait_d_o,
  output logic active_o,
  output logic in_go_o,
  output logic to_go_o
);
  logic wait_q;

  assign active_o = start_i | wait_q;
  assign in_go_o  = active_o & offer_i;
  assign to_go_o  = expired_i & ~offer_i;
  assign wait_d_o = active_o & ~offer_i & ~expired_i;
  assign wait_q_o = wait_q;

  always_ff @(posedge clk) begin
    if (rst) wait_q <= 1'b0;
    else     wait_q <= wait_d_o;
  end
endmodule

// File: rtl/gic_finish.sv
module gic_finish #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] done_i,
  output logic          finish_o
);
  always_ff @(posedge clk) begin
    if (rst) finish_o <= 1'b0;
    else     finish_o <= |done_i;
  end
endmodule

// File: rtl/gic_unit.sv
module gic_unit #(
  parameter int N  = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          offer_i,
  input  logic [DW-1:0] data_i,
  input  logic          in_done_i,
  input  logic          to_done_i,
  output logic          recv_rdy_o,
  output logic          in_go_o,
  output logic          to_go_o,
  output logic [DW-1:0] data_o,
  output logic          finish_o
);
  logic wait_q, wait_d, expired;

  gic_timer #(.N(N)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .armed_i(wait_q),
    .run_i(wait_d), .expired_o(expired)
  );

  gic_guard u_guard (
    .clk(clk), .rst(rst), .start_i(start_i), .offer_i(offer_i),
    .expired_i(expired), .wait_q_o(wait_q), .wait_d_o(wait_d),
    .active_o(recv_rdy_o), .in_go_o(in_go_o), .to_go_o(to_go_o)
  );

  gic_finish #(.NB(2)) u_fin (
    .clk(clk), .rst(rst), .done_i({to_done_i, in_done_i}),
    .finish_o(finish_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          data_o <= '0;
    else if (in_go_o) data_o <= data_i;
  end
endmodule

// File: rtl/gic_unit_chk.sv
module gic_unit_chk #(
  parameter int N  = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          offer_i,
  input logic [DW-1:0] data_i,
  input logic          in_done_i,
  input logic          to_done_i,
  input logic          recv_rdy_o,
  input logic          in_go_o,
  input logic          to_go_o,
  input logic [DW-1:0] data_o,
  input logic          finish_o
);
  int unsigned el;

  always_ff @(posedge clk) begin
    if (rst)             el <= 0;
    else if (start_i)    el <= 1;
    else if (recv_rdy_o) el <= el + 1;
  end

  assert_ready_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |-> recv_rdy_o);
  assert_take_R3: assert property (@(posedge clk) disable iff (rst)
    (recv_rdy_o && offer_i) |-> in_go_o);
  assert_latch_R4: assert property (@(posedge clk) disable iff (rst)
    in_go_o |=> (data_o == $past(data_i)));
  assert_deadline_R5: assert property (@(posedge clk) disable iff (rst)
    to_go_o |-> (el == N && !start_i));
  assert_priority_R6: assert property (@(posedge clk) disable iff (rst)
    to_go_o |-> !offer_i);
  assert_cancel_R7: assert property (@(posedge clk) disable iff (rst)
    in_go_o |=> (!recv_rdy_o || start_i));
  assert_finish_R8: assert property (@(posedge clk) disable iff (rst)
    (in_done_i || to_done_i) |=> finish_o);
  assert_no_finish_R8: assert property (@(posedge clk) disable iff (rst)
    !(in_done_i || to_done_i) |=> !finish_o);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !recv_rdy_o |-> (!in_go_o && !to_go_o));
endmodule

bind gic_unit gic_unit_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .offer_i(offer_i),
  .data_i(data_i), .in_done_i(in_done_i), .to_done_i(to_done_i),
  .recv_rdy_o(recv_rdy_o), .in_go_o(in_go_o), .to_go_o(to_go_o),
  .data_o(data_o), .finish_o(finish_o)
);

// File: tb/sim_gic_unit.sv
module sim_gic_unit;
  localparam int CLK_P = 10;
  localparam int TMO   = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, offer_i = 1'b0, in_done_i = 1'b0, to_done_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       recv_rdy_o, in_go_o, to_go_o, finish_o;
  logic [7:0] data_o;

  int total = 0, bad = 0;
  bit ended = 0;

  // reference model state
  bit       m_wait = 0;
  int       m_el = 0;
  bit [7:0] m_data = '0;
  bit       m_fin = 0;

  always #(CLK_P/2) clk = ~clk;

  gic_unit #(.N(TMO), .DW(8)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .offer_i(offer_i),
    .data_i(data_i), .in_done_i(in_done_i), .to_done_i(to_done_i),
    .recv_rdy_o(recv_rdy_o), .in_go_o(in_go_o), .to_go_o(to_go_o),
    .data_o(data_o), .finish_o(finish_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit o, input logic [7:0] d,
                      input bit idn, input bit tdn, input string tag);
    bit act, e_in, e_to;
    int el;
    @(negedge clk);
    start_i = s; offer_i = o; data_i = d; in_done_i = idn; to_done_i = tdn;
    #1;
    act  = s || m_wait;
    el   = s ? 0 : m_el;
    e_in = act && o;
    e_to = m_wait && !s && !o && (m_el == TMO);
    chk(recv_rdy_o == act,  {tag, "/R2"}, "recv_rdy", recv_rdy_o, act);
    chk(in_go_o == e_in,    {tag, "/R3"}, "in_go",    in_go_o, e_in);
    chk(to_go_o == e_to,    {tag, "/R5"}, "to_go",    to_go_o, e_to);
    chk(data_o == m_data,   {tag, "/R4"}, "data",     data_o, m_data);
    chk(finish_o == m_fin,  {tag, "/R8"}, "finish",   finish_o, m_fin);
    m_wait = act && !o && !(el == TMO);
    m_el   = el + 1;
    if (e_in) m_data = d;
    m_fin  = idn || tdn;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!ended) begin
      ended = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(recv_rdy_o == 0 && in_go_o == 0 && to_go_o == 0 && finish_o == 0,
        "R1", "outputs in reset", {recv_rdy_o, in_go_o, to_go_o, finish_o}, 0);
    chk(data_o == 0, "R1", "data in reset", data_o, 0);
    rst = 1'b0;
    idle(2, "R1");

    // R9: offers while idle are ignored
    for (int i = 0; i < 3; i++) step(0, 1, 8'hA0 + 8'(i), 0, 0, "R9");

    // input before the deadline, then timer must stay cancelled (R7)
    step(1, 0, 8'h00, 0, 0, "R3");
    idle(2, "R3");
    step(0, 1, 8'h3C, 0, 0, "R3");
    idle(2, "R4");
    step(0, 0, 8'h00, 1, 0, "R8");
    idle(TMO + 2, "R7");

    // R6: input exactly in the deadline cycle
    step(1, 0, 8'h00, 0, 0, "R6");
    idle(TMO - 1, "R6");
    step(0, 1, 8'h5A, 0, 0, "R6");
    idle(TMO + 1, "R6");

    // R5: no input at all
    step(1, 0, 8'h00, 0, 0, "R5");
    idle(TMO + 2, "R5");
    step(0, 0, 8'h00, 0, 1, "R8");
    idle(2, "R8");

    // R3: offer already present on the start cycle
    step(1, 1, 8'hC3, 0, 0, "R3");
    idle(TMO + 1, "R7");

    // R10: restart during a wait
    step(1, 0, 8'h00, 0, 0, "R10");
    idle(3, "R10");
    step(1, 0, 8'h00, 0, 0, "R10");
    idle(TMO + 2, "R10");

    // R8: both done pulses together, then back to back
    step(0, 0, 8'h00, 1, 1, "R8");
    step(0, 0, 8'h00, 1, 0, "R8");
    idle(2, "R8");

    // R1 result retained: data keeps last taken word while idle (R4)
    step(0, 1, 8'hFF, 0, 0, "R9");
    idle(1, "R4");

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule